// File: doc/BRIEF.md
# Delay-Line Comb and All-Pass Section

This block is a per-sample audio effect built on a single circular delay memory. Each accepted input sample yields exactly one output sample. A mode input selects one of three difference equations. The feedforward comb (echo) adds a scaled copy of an older input to the current one. The feedback comb mixes the scaled current input with a scaled older output. The all-pass section combines a negated scaled input, an older input and a scaled older output.

Each memory word holds both the input sample and the output sample of one time step. This lets all three equations share one address path. The delay length is counted in whole samples and is clamped into the range the memory can hold. After reset, delayed terms read as zero until enough samples have been written. The memory contents are never cleared for this.

Gains are signed Q1.15 values. Every product is rounded back to the sample width. Every final sum is saturated, so a recursive loop cannot flip sign when it overflows.

Top module: `dly_comb_ap`

## Requirements
- R1: When `mode` is 0 or 3, the output is sat(x(n) + rnd(a·x(n−m))). This is the feedforward comb.
- R2: When `mode` is 1, the output is sat(rnd(a·x(n)) + rnd(b·y(n−m))), where y is the block's own past output. This is the feedback comb.
- R3: When `mode` is 2, the output is sat(−rnd(a·x(n)) + x(n−m) + rnd(b·y(n−m))). This is the all-pass section.
- R4: The delay m counts accepted samples, not clock cycles. It stays correct after the write position wraps around a memory of DEPTH entries, including m = DEPTH.
- R5: A `delay_len` of 0 behaves as m = 1. A `delay_len` above DEPTH behaves as m = DEPTH.
- R6: After reset, x(n−m) and y(n−m) read as 0 until n ≥ m samples have been accepted, even if the memory still holds data from before the reset.
- R7: The result saturates to the range −2^(W−1) to 2^(W−1)−1 instead of wrapping.
- R8: rnd(g·v) is the full signed product plus 2^14, then arithmetically shifted right by 15.
- R9: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high, and carries that sample's result. With `in_valid` low, `out_valid` stays low and `out_sample` holds its value.
- R10: While `rst_n` is low, and until the first accepted sample, `out_valid` and `out_sample` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | W | Signed input sample x(n) |
| delay_len | input | LW | Requested delay m in samples |
| gain_a | input | 16 | Signed Q1.15 gain a |
| gain_b | input | 16 | Signed Q1.15 gain b |
| mode | input | 2 | 0/3 feedforward, 1 feedback, 2 all-pass |
| out_valid | output | 1 | Result strobe |
| out_sample | output | W | Signed result y(n) |

## Verification
An impulse followed by silence is run through each mode. In the feedforward mode it shows a single echo at lag m. In the feedback mode it shows a geometric train of echoes spaced m apart. In the all-pass mode it shows the negated direct tap and then the tail.

Long pseudo-random streams with m at 37, at DEPTH and at clamped extremes check the addressing across many pointer wraps, where an off-by-one lag would show at once. Near-full-scale inputs with gains close to one separate saturation from wrap-around. Small odd inputs at half gain expose the rounding direction of negative products. A second reset over a filled memory shows whether stale data leaks into the delayed terms.

// File: rtl/dly_comb_ap.sv
`timescale 1ns/1ps
module dly_comb_ap #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_sample,
  input  logic [LW-1:0]       delay_len,
  input  logic signed [15:0]  gain_a,
  input  logic signed [15:0]  gain_b,
  input  logic [1:0]          mode,
  output logic                out_valid,
  output logic signed [W-1:0] out_sample
);
  localparam int GW = 16;
  localparam int AW = $clog2(DEPTH);
  typedef logic signed [W+GW-1:0] prod_t;
  typedef logic signed [W+2:0]    acc_t;
  localparam prod_t RND  = prod_t'(1) <<< (GW-2);
  localparam acc_t  SMAX = acc_t'((64'sd1 <<< (W-1)) - 1);
  localparam acc_t  SMIN = -SMAX - acc_t'(1);

  logic [AW-1:0]       wp;
  logic [AW:0]         fill, m_eff, rd_full;
  logic [2*W-1:0]      mem [DEPTH];
  logic [2*W-1:0]      rd_word;
  logic                hit;
  logic signed [W-1:0] dx, dy, y_next;
  logic signed [W:0]   ax, adx, bdy;
  acc_t                acc;

  function automatic logic signed [W:0] qmul(input logic signed [GW-1:0] g,
                                             input logic signed [W-1:0] v);
    prod_t p;
    p = prod_t'(g) * prod_t'(v);
    p = p + RND;
    return p[GW-1 +: W+1];
  endfunction

  always_comb begin
    if (delay_len == '0)                    m_eff = (AW+1)'(1);
    else if (delay_len > LW'(DEPTH))        m_eff = (AW+1)'(DEPTH);
    else                                    m_eff = (AW+1)'(delay_len);
  end

  assign rd_full = ({1'b0, wp} >= m_eff) ? {1'b0, wp} - m_eff
                                         : {1'b0, wp} + (AW+1)'(DEPTH) - m_eff;
  assign rd_word = mem[rd_full[AW-1:0]];
  assign hit     = fill >= m_eff;
  assign dx      = hit ? rd_word[2*W-1:W] : '0;
  assign dy      = hit ? rd_word[W-1:0]   : '0;

  assign ax  = qmul(gain_a, in_sample);
  assign adx = qmul(gain_a, dx);
  assign bdy = qmul(gain_b, dy);

  always_comb begin
    case (mode)
      2'd1:    acc = acc_t'(ax) + acc_t'(bdy);
      2'd2:    acc = acc_t'(bdy) - acc_t'(ax) + acc_t'(dx);
      default: acc = acc_t'(in_sample) + acc_t'(adx);
    endcase
  end

  assign y_next = (acc > SMAX) ? W'(SMAX) : (acc < SMIN) ? W'(SMIN) : acc[W-1:0];

  always_ff @(posedge clk)
    if (in_valid) mem[wp] <= {in_sample, y_next};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp         <= '0;
      fill       <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wp         <= ({1'b0, wp} == (AW+1)'(DEPTH-1)) ? '0 : wp + 1'b1;
        fill       <= (fill == (AW+1)'(DEPTH)) ? fill : fill + 1'b1;
        out_sample <= y_next;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample)));
  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wp} < (AW+1)'(DEPTH)) && (rd_full < (AW+1)'(DEPTH)));
  // R6
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill < (AW+1)'(DEPTH)) |=> fill == $past(fill) + 1'b1);
  // R6
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));
endmodule

// File: tb/dly_comb_ap_bench.sv
`timescale 1ns/1ps
module dly_comb_ap_bench;
  localparam int W = 16;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic [LW-1:0] delay_len = '0;
  logic signed [15:0] gain_a = '0, gain_b = '0;
  logic [1:0] mode = '0;
  logic out_valid;
  logic signed [W-1:0] out_sample;

  dly_comb_ap #(.W(W), .DEPTH(DEPTH), .LW(LW)) u_dly_comb_ap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .delay_len(delay_len), .gain_a(gain_a), .gain_b(gain_b), .mode(mode),
    .out_valid(out_valid), .out_sample(out_sample));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  int xh[$], yh[$];
  int seed = 7;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input int g, input int v);
    longint p = longint'(g) * longint'(v);
    return int'((p + 64'sd16384) >>> 15);
  endfunction

  function automatic int sat(input int s);
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  function automatic int nextval();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'hFFFF) - 32768;
  endfunction

  task automatic send(input int x, input int m, input int a, input int b,
                      input int md, input string tag);
    int n, me, dx, dy, s, y;
    n = xh.size();
    me = (m == 0) ? 1 : (m > DEPTH) ? DEPTH : m;
    dx = (n >= me) ? xh[n-me] : 0;
    dy = (n >= me) ? yh[n-me] : 0;
    case (md)
      1: s = rnd(a, x) + rnd(b, dy);
      2: s = -rnd(a, x) + dx + rnd(b, dy);
      default: s = x + rnd(a, dx);
    endcase
    y = sat(s);
    xh.push_back(x);
    yh.push_back(y);
    exp_q.push_back(y);
    tag_q.push_back(tag);
    @(negedge clk);
    in_sample = W'(x);
    delay_len = LW'(m);
    gain_a = 16'(a);
    gain_b = 16'(b);
    mode = 2'(md);
    in_valid = 1'b1;
  endtask

  task automatic gap(input int k);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R10
    chk(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
    chk(out_sample == '0, "R10 out_sample in reset", int'(out_sample), 0);
    xh.delete();
    yh.delete();
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    chk(out_sample == '0, "R10 out_sample after reset", int'(out_sample), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected out_valid", int'(out_sample), 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(out_sample) == e, t, int'(out_sample), e);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    do_reset();

    // R1 R6: impulse through feedforward comb, m=3, a=0.5
    send(1000, 3, 16384, 0, 0, "R1 ff impulse");
    for (int i = 0; i < 7; i++) send(0, 3, 16384, 0, 0, "R1 ff tail");
    for (int i = 0; i < 10; i++) send(nextval() / 2, 3, -20000, 0, 3, "R1 mode3 ff");
    gap(3);

    // R2: feedback comb impulse, m=4, a=0.75, b=0.5
    do_reset();
    send(8000, 4, 24576, 16384, 1, "R2 fb impulse");
    for (int i = 0; i < 15; i++) send(0, 4, 24576, 16384, 1, "R2 fb tail");
    for (int i = 0; i < 12; i++) send(nextval(), 4, 20000, -26000, 1, "R2 fb random");
    gap(2);

    // R3: all-pass, m=2
    do_reset();
    send(10000, 2, 16384, 16384, 2, "R3 ap impulse");
    for (int i = 0; i < 9; i++) send(0, 2, 16384, 16384, 2, "R3 ap tail");
    for (int i = 0; i < 12; i++) send(nextval() / 2, 5, 12000, -12000, 2, "R3 ap random");
    gap(2);

    // R4: long runs across pointer wrap
    for (int i = 0; i < 150; i++) send(nextval(), 37, 30000, 0, 0, "R4 m=37 wrap");
    for (int i = 0; i < 150; i++) send(nextval() / 2, DEPTH, 16384, 16000, 2, "R4 m=DEPTH wrap");
    gap(2);

    // R5: clamping of delay_len
    for (int i = 0; i < 20; i++) send(nextval(), 0, 16384, 0, 0, "R5 m=0 as 1");
    for (int i = 0; i < 90; i++) send(nextval(), 100, -16384, 0, 0, "R5 m=100 as DEPTH");
    gap(2);

    // R6: reset over a filled memory, delayed terms must read 0
    do_reset();
    for (int i = 0; i < 8; i++) send(1000 + i, 5, 32767, 32767, 2, "R6 no stale delay");
    gap(2);

    // R7: saturation
    do_reset();
    send(30000, 1, 32767, 0, 0, "R7 pos sat");
    send(30000, 1, 32767, 0, 0, "R7 pos sat");
    send(-30000, 1, 32767, 0, 0, "R7 neg sat");
    send(-30000, 1, 32767, 0, 0, "R7 neg sat");
    for (int i = 0; i < 6; i++) send(30000, 1, 32767, 32767, 1, "R7 fb sat no wrap");
    for (int i = 0; i < 4; i++) send(-32768, 1, -32768, 32767, 2, "R7 ap sat");
    gap(2);

    // R8: rounding of products, mode 1 with b=0 gives rnd(a*x)
    do_reset();
    send(3, 1, 16384, 0, 1, "R8 round 1.5 up");
    send(-3, 1, 16384, 0, 1, "R8 round -1.5");
    send(1, 1, 16384, 0, 1, "R8 round 0.5");
    send(-1, 1, 16384, 0, 1, "R8 round -0.5");
    send(-32768, 1, -32768, 0, 1, "R8 full scale product");
    send(5, 1, 13107, 0, 1, "R8 round small");

    // R9: hold while idle
    gap(1);
    held = int'(out_sample);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle out_valid", int'(out_valid), 0);
    chk(int'(out_sample) == held, "R9 idle hold", int'(out_sample), held);
    chk(exp_q.size() == 0, "R9 all results produced", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule